// File: doc/BRIEF.md
# Multi-Rail Power-Good Reset Supervisor

This block watches three regulator channels and drives a single reset-release output. The output is high only when every enabled channel is in regulation and has stayed there for a programmable hold-off period counted in clock cycles. Each channel reports an enable, an "upper threshold reached" flag and a "lower threshold lost" flag. All three are taken as already synchronized to the clock. Together the two comparator flags give each channel a hysteretic good/bad state. A global input-supply undervoltage warning also pulls the output low.

Channels whose enable is low are masked out. If the output is high and another channel is enabled, the output drops and a complete new hold-off must run. A channel that faults and then recovers restarts the hold-off from zero, and no soft-start request is made for it. The only source of a one-cycle soft-start request pulse for a channel is a rising edge on that channel's enable.

Top module: `rail_reset_supervisor`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `resetRelease` is 0 and `softStartReq` is 0. Reset clears every channel's good state, so a channel has to report its upper flag again before it counts as good.
- R2: A channel becomes good on an edge where it is enabled, `lowerLost` is 0 and `upperOk` is 1. It stays good while both flags are 0. It stops being good on an edge where `lowerLost` is 1 or its enable is 0.
- R3: Let H be the value of `holdCycles`. Suppose the last enabled channel's `upperOk` is first sampled at edge t, and the supply warning is low. Then `resetRelease` rises at edge t+1+H. This includes H = 0, which gives a rise at edge t+1.
- R4: `holdCycles` is sampled only when the hold-off starts. A change to it during the count does not alter the release time.
- R5: A channel whose enable is 0 has no influence on `resetRelease`, whatever its flags show.
- R6: If any enabled channel has `lowerLost` at 1 on an edge, `resetRelease` is 0 after that edge. Once the channel reports `upperOk` again, the full hold-off of R3 runs again from zero.
- R7: A channel enable that rises while `resetRelease` is high drives `resetRelease` to 0 on the next edge. Release then needs a fresh hold-off measured from that channel's upper flag.
- R8: `softStartReq[i]` is high for exactly one cycle, starting on the edge after `chanEn[i]` rises. It is never raised by a threshold fault.
- R9: When no channel is enabled, `resetRelease` is 0 after the next edge.
- R10: A high `supplyWarn` drives `resetRelease` to 0 on the next edge. It does not touch channel good states and raises no soft-start request. After the warning clears, with every enabled channel still good, the output rises H+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chanEn | input | NUM_CH | Per-channel enable |
| upperOk | input | NUM_CH | Feedback has reached the upper (good) threshold |
| lowerLost | input | NUM_CH | Feedback is below the lower (fail) threshold |
| supplyWarn | input | 1 | Input-supply undervoltage warning |
| holdCycles | input | TIMER_W | Hold-off length in clock cycles |
| resetRelease | output | 1 | High when all enabled rails are good and the hold-off has elapsed |
| softStartReq | output | NUM_CH | One-cycle soft-start request per channel |

## Verification
Every fault-type stimulus takes effect one edge after it is sampled: a lower-threshold loss, the supply warning, enabling a new channel, or disabling the last one. The release takes H+2 edges from the point where the upper flag is driven, because the good state of the channel is itself a register. A soft-start pulse shows up one edge after its enable rises. The bench drives inputs on the falling edge and counts falling edges from each stimulus until the output is due, then compares against exactly that count. A cycle-level model built from the requirements is also checked on every falling edge during constrained-random operation.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GOOD = 2'd2
  } supState_t;

  typedef struct packed {
    logic loadTimer;
    logic runTimer;
  } timerStrobe_t;
endpackage

// File: rtl/rail_sup_channel.sv
module rail_sup_channel (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic upperOk,
  input  logic lowerLost,
  output logic goodFlag,
  output logic softStart
);
  logic enPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      goodFlag  <= 1'b0;
      enPrev    <= 1'b0;
      softStart <= 1'b0;
    end else begin
      enPrev    <= enable;
      softStart <= enable & ~enPrev;
      if (!enable || lowerLost) goodFlag <= 1'b0;
      else if (upperOk)         goodFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/rail_sup_datapath.sv
module rail_sup_datapath
  import rail_sup_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  chanEn,
  input  logic [NUM_CH-1:0]  upperOk,
  input  logic [NUM_CH-1:0]  lowerLost,
  input  logic               supplyWarn,
  input  logic [TIMER_W-1:0] holdCycles,
  input  timerStrobe_t       strobe,
  output logic               railsReady,
  output logic               holdZero,
  output logic               timerLast,
  output logic [NUM_CH-1:0]  softStartReq
);
  logic [NUM_CH-1:0]  goodFlags;
  logic [TIMER_W-1:0] count;

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    rail_sup_channel uChan (
      .clk       (clk),
      .rst       (rst),
      .enable    (chanEn[i]),
      .upperOk   (upperOk[i]),
      .lowerLost (lowerLost[i]),
      .goodFlag  (goodFlags[i]),
      .softStart (softStartReq[i])
    );
  end

  logic anyEnabled, anyFault, allGood;
  always_comb begin
    anyEnabled = |chanEn;
    anyFault   = |(chanEn & lowerLost);
    allGood    = &(goodFlags | ~chanEn);
    railsReady = anyEnabled & allGood & ~anyFault & ~supplyWarn;
  end

  always_ff @(posedge clk) begin
    if (rst)                   count <= '0;
    else if (strobe.loadTimer) count <= holdCycles;
    else if (strobe.runTimer)  count <= count - 1'b1;
  end

  assign holdZero  = (holdCycles == '0);
  assign timerLast = (count == TIMER_W'(1));
endmodule

// File: rtl/rail_sup_ctrl.sv
module rail_sup_ctrl
  import rail_sup_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         railsReady,
  input  logic         holdZero,
  input  logic         timerLast,
  output timerStrobe_t strobe,
  output logic         release_o
);
  supState_t state, nextState;

  always_comb begin
    nextState        = state;
    strobe.loadTimer = 1'b0;
    strobe.runTimer  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (railsReady) begin
          strobe.loadTimer = 1'b1;
          nextState        = holdZero ? ST_GOOD : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!railsReady) nextState = ST_IDLE;
        else begin
          strobe.runTimer = 1'b1;
          if (timerLast) nextState = ST_GOOD;
        end
      end
      ST_GOOD: begin
        if (!railsReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign release_o = (state == ST_GOOD);
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
  import rail_sup_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  chanEn,
  input  logic [NUM_CH-1:0]  upperOk,
  input  logic [NUM_CH-1:0]  lowerLost,
  input  logic               supplyWarn,
  input  logic [TIMER_W-1:0] holdCycles,
  output logic               resetRelease,
  output logic [NUM_CH-1:0]  softStartReq
);
  timerStrobe_t strobe;
  logic railsReady, holdZero, timerLast;

  rail_sup_datapath #(.NUM_CH(NUM_CH), .TIMER_W(TIMER_W)) uData (
    .clk          (clk),
    .rst          (rst),
    .chanEn       (chanEn),
    .upperOk      (upperOk),
    .lowerLost    (lowerLost),
    .supplyWarn   (supplyWarn),
    .holdCycles   (holdCycles),
    .strobe       (strobe),
    .railsReady   (railsReady),
    .holdZero     (holdZero),
    .timerLast    (timerLast),
    .softStartReq (softStartReq)
  );

  rail_sup_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .railsReady (railsReady),
    .holdZero   (holdZero),
    .timerLast  (timerLast),
    .strobe     (strobe),
    .release_o  (resetRelease)
  );
endmodule

// File: rtl/rail_sup_checker.sv
module rail_sup_checker #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] lowerLost,
  input logic              supplyWarn,
  input logic              resetRelease,
  input logic [NUM_CH-1:0] softStartReq
);
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!resetRelease && softStartReq == '0));

  assert_fault_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (|(chanEn & lowerLost)) |=> !resetRelease);

  assert_warn_drop_R10: assert property (@(posedge clk) disable iff (rst)
    supplyWarn |=> !resetRelease);

  assert_none_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    (chanEn == '0) |=> !resetRelease);

  assert_new_enable_R7: assert property (@(posedge clk) disable iff (rst)
    (|(chanEn & ~$past(chanEn))) |=> !resetRelease);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (softStartReq != '0) |=> ((softStartReq & $past(softStartReq)) == '0));

  assert_rise_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(resetRelease) |-> ($past(chanEn) != '0));
endmodule

bind rail_reset_supervisor rail_sup_checker #(.NUM_CH(NUM_CH)) uChecker (
  .clk          (clk),
  .rst          (rst),
  .chanEn       (chanEn),
  .lowerLost    (lowerLost),
  .supplyWarn   (supplyWarn),
  .resetRelease (resetRelease),
  .softStartReq (softStartReq)
);

// File: tb/rail_reset_supervisor_test.sv
module rail_reset_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] chanEn = '0;
  logic [NCH-1:0] upperOk = '0;
  logic [NCH-1:0] lowerLost = '0;
  logic supplyWarn = 1'b0;
  logic [TW-1:0] holdCycles = TW'(4);
  logic resetRelease;
  logic [NCH-1:0] softStartReq;

  int errors = 0;
  int checks = 0;
  int lvl [NCH];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_reset_supervisor #(.NUM_CH(NCH), .TIMER_W(TW)) uut (
    .clk(clk), .rst(rst), .chanEn(chanEn), .upperOk(upperOk),
    .lowerLost(lowerLost), .supplyWarn(supplyWarn), .holdCycles(holdCycles),
    .resetRelease(resetRelease), .softStartReq(softStartReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // level 0: below lower threshold, 1: between thresholds, 2: above upper threshold
  task automatic applyLevels();
    for (int i = 0; i < NCH; i++) begin
      upperOk[i]   = (lvl[i] == 2);
      lowerLost[i] = (lvl[i] == 0);
    end
  endtask

  // reference model built from the requirements
  logic [NCH-1:0] mEnPrev, mGood, mSs;
  logic mOut;
  int mRun;
  logic [TW-1:0] mH, hEff;

  function automatic logic modelReady(input logic [NCH-1:0] en, input logic [NCH-1:0] lost,
                                      input logic [NCH-1:0] good, input logic warn);
    return (en != '0) && ((en & lost) == '0) && ((good | ~en) == '1) && !warn;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mEnPrev <= '0; mGood <= '0; mSs <= '0; mOut <= 1'b0; mRun <= 0; mH <= '0;
    end else begin
      mSs <= chanEn & ~mEnPrev;
      mEnPrev <= chanEn;
      for (int i = 0; i < NCH; i++) begin
        if (!chanEn[i] || lowerLost[i]) mGood[i] <= 1'b0;
        else if (upperOk[i])            mGood[i] <= 1'b1;
      end
      if (!modelReady(chanEn, lowerLost, mGood, supplyWarn)) begin
        mRun <= 0; mOut <= 1'b0;
      end else begin
        hEff = (mRun == 0) ? holdCycles : mH;
        if (mRun == 0) mH <= holdCycles;
        mOut <= (mRun >= int'(hEff));
        if (mRun < (1 << 26)) mRun <= mRun + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3 R6 model resetRelease", int'(resetRelease), int'(mOut));
      chk("R8 model softStartReq", int'(softStartReq), int'(mSs));
    end
  end

  task automatic expectRise(input string tag, input int want, input int changeAt, input int newH);
    int got = 0;
    for (int k = 1; k <= want + 3 && got == 0; k++) begin
      @(negedge clk);
      if (resetRelease) got = k;
      if (k == changeAt) holdCycles = TW'(newH);
    end
    chk(tag, got, want);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) lvl[i] = 1;
    applyLevels();
    repeat (3) @(negedge clk);
    chk("R1 out in reset", int'(resetRelease), 0);
    chk("R1 pulses in reset", int'(softStartReq), 0);
    rst = 1'b0;

    // R8 enable pulse, R2 between-thresholds does not count as good
    chanEn[0] = 1'b1;
    @(negedge clk); chk("R8 pulse ch0", int'(softStartReq), 1);
    @(negedge clk); chk("R8 pulse width", int'(softStartReq), 0);
    chk("R2 not good between thresholds", int'(resetRelease), 0);

    lvl[0] = 2; applyLevels();
    expectRise("R3 hold-off length", 6, 0, 0);

    lvl[0] = 1; applyLevels();
    repeat (5) @(negedge clk);
    chk("R2 hysteresis keeps good", int'(resetRelease), 1);

    lvl[0] = 0; applyLevels();
    @(negedge clk);
    chk("R6 fault drop", int'(resetRelease), 0);
    chk("R8 no pulse on fault", int'(softStartReq), 0);
    lvl[0] = 2; applyLevels();
    expectRise("R6 restart from zero", 6, 0, 0);

    lvl[1] = 0; applyLevels();
    repeat (4) @(negedge clk);
    chk("R5 disabled channel masked", int'(resetRelease), 1);

    chanEn[1] = 1'b1;
    @(negedge clk);
    chk("R7 new enable drops output", int'(resetRelease), 0);
    chk("R7 R8 pulse ch1", int'(softStartReq), 2);
    lvl[1] = 2; applyLevels();
    expectRise("R7 fresh hold-off", 6, 0, 0);

    holdCycles = TW'(6);
    lvl[0] = 0; applyLevels();
    @(negedge clk);
    lvl[0] = 2; applyLevels();
    expectRise("R4 hold sampled at start", 8, 2, 1);
    holdCycles = TW'(4);

    supplyWarn = 1'b1;
    @(negedge clk);
    chk("R10 warn drops output", int'(resetRelease), 0);
    chk("R10 no pulse on warn", int'(softStartReq), 0);
    supplyWarn = 1'b0;
    expectRise("R10 good flags kept", 5, 0, 0);

    chanEn = '0;
    @(negedge clk);
    chk("R9 last disable", int'(resetRelease), 0);

    holdCycles = '0;
    lvl[2] = 2; applyLevels();
    chanEn[2] = 1'b1;
    expectRise("R3 zero hold", 2, 0, 0);

    // constrained random phase, checked against the model
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if ($urandom_range(0, 39) == 0) chanEn[i] = ~chanEn[i];
        if ($urandom_range(0, 9) == 0) begin
          if ($urandom_range(0, 1) == 1) lvl[i] = (lvl[i] < 2) ? lvl[i] + 1 : 2;
          else if ($urandom_range(0, 3) == 0) lvl[i] = (lvl[i] > 0) ? lvl[i] - 1 : 0;
        end
      end
      applyLevels();
      supplyWarn = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 19) == 0) holdCycles = TW'($urandom_range(0, 12));
    end

    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule